// File: doc/BRIEF.md
# External Clock Correction Application Scheduler

This block sits between two host-written correction registers and the time-base correction unit of a time-triggered bus controller. The host posts an external offset correction and an external rate correction, each through its own write strobe. The block watches three things: the 6-bit communication cycle counter, the pulse that marks the end of each static segment, and the pulse that marks the start of each network idle time (NIT). From these it decides when each value may reach the correction unit.

Corrections are only handed over once per even/odd cycle pair, in the NIT of the odd cycle. The write window for a pair starts with its even cycle and closes at the end of the odd cycle's static segment. A value written inside the window is released at that odd NIT. A value written after the window closes moves to the odd NIT one full pair later. The offset is used in that NIT. The rate value governs the cycle pair that follows it.

At every odd NIT each path puts out a one-clock apply strobe. A valid flag is raised alongside the strobe only when a fresh value is being handed over. Each written value is handed over exactly once.

Top module: `ext_corr_sched`

## Requirements
- R1: A synchronous active-high reset clears all held state. While reset is high and after it is released, every output is 0. No valid is raised until the host has written the path.
- R2: Each path's apply output pulses for exactly one clock. The pulse comes on the clock after the first clock of an odd cycle (cycle_count bit 0 = 1) in which nit_start is sampled high. A nit_start in an even cycle produces no pulse.
- R3: A write is on time in two cases: it falls in an even cycle, or it falls in an odd cycle up to and including the clock on which static_end is high. An on-time write is released with valid = 1 at the apply pulse of that pair's odd NIT. A static_end in an even cycle does not close the window.
- R4: A write is late when it falls in an odd cycle after its static_end clock, including the clock of nit_start. A late write is released at the odd NIT two cycles later, and not at the current one.
- R5: The value released is the 2-bit word last written before the window closed, passed unchanged. The encodings are 00 = no correction, 01 = add one, 11 = subtract one, and 10 is reserved.
- R6: Once a value has been released, the later apply pulses of that path carry valid = 0 and value = 00 until the host writes again. Value is 00 whenever valid is 0.
- R7: A second write before the window closes replaces the held value, and only the last one is released. A write after the close is kept for the next pair and does not disturb the value already committed.
- R8: The rate path follows the same window and release rules as the offset path, and the two paths are independent. The rate value released at the odd NIT of cycle 2n+1 governs the pair [2n+2, 2n+3].
- R9: If nit_start or static_end stays high for several clocks of one cycle, only the first clock counts. This gives one apply pulse per odd cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycle_count | input | CYCLE_W (6) | Current communication cycle number; bit 0 gives parity |
| static_end | input | 1 | High at the end of the static segment |
| nit_start | input | 1 | High at the start of the network idle time |
| ofs_wr | input | 1 | Host write strobe for the offset correction |
| ofs_wdata | input | VAL_W (2) | Offset correction selector being written |
| rate_wr | input | 1 | Host write strobe for the rate correction |
| rate_wdata | input | VAL_W (2) | Rate correction selector being written |
| ofs_apply | output | 1 | One-clock offset apply pulse at each odd NIT |
| ofs_valid | output | 1 | A fresh offset value accompanies ofs_apply |
| ofs_value | output | VAL_W (2) | Offset selector released, 00 when not valid |
| rate_apply | output | 1 | One-clock rate apply pulse at each odd NIT |
| rate_valid | output | 1 | A fresh rate value accompanies rate_apply |
| rate_value | output | VAL_W (2) | Rate selector released, 00 when not valid |

## Verification
The bench builds the block with the default 6-bit cycle counter and 2-bit selectors. It drives an 8-clock cycle with static_end at clock 4 and nit_start at clock 5, sometimes held through clock 6. On that frame it sweeps one write per path over every clock of an even and an odd cycle and over all four selector codes. It runs the sweep from cycle 0 and from cycle 62, so the counter wraps while a late value is waiting. The small counter and short cycle make every window position, every code and the wrap point reachable in a few thousand clocks. A further set of double writes covers replacement before and after the close.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

  // Number of correction paths: index 0 is offset, index 1 is rate.
  localparam int unsigned NPATH     = 2;
  localparam int unsigned PATH_OFS  = 0;
  localparam int unsigned PATH_RATE = 1;

  // Correction selector encodings.
  typedef enum logic [1:0] {
    CORR_NONE = 2'b00,
    CORR_INC  = 2'b01,
    CORR_RSVD = 2'b10,
    CORR_DEC  = 2'b11
  } corr_sel_e;

  // Qualified pair events: window close and release point, odd cycles only.
  typedef struct packed {
    logic close;
    logic fire;
  } pair_evt_t;

endpackage

// File: rtl/ecs_once.sv
// Passes the first clock of a trigger within one cycle number; repeats of the
// trigger in the same cycle are swallowed.
module ecs_once #(
  parameter int unsigned CYCLE_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CYCLE_W-1:0] cycle_count,
  input  logic               trig,
  output logic               first
);

  logic               seen_q;
  logic [CYCLE_W-1:0] cyc_q;
  logic               same_cycle;

  assign same_cycle = seen_q & (cyc_q == cycle_count);
  assign first      = trig & ~same_cycle;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      cyc_q  <= '0;
    end else if (first) begin
      seen_q <= 1'b1;
      cyc_q  <= cycle_count;
    end
  end

endmodule

// File: rtl/ecs_phase.sv
// Turns raw segment markers into odd-cycle pair events.
module ecs_phase #(
  parameter int unsigned CYCLE_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CYCLE_W-1:0] cycle_count,
  input  logic               static_end,
  input  logic               nit_start,
  output ecs_pkg::pair_evt_t evt
);

  localparam int unsigned NEVT = 2;
  localparam int unsigned EVT_CLOSE = 0;
  localparam int unsigned EVT_FIRE  = 1;

  logic            odd_cycle;
  logic [NEVT-1:0] raw;
  logic [NEVT-1:0] first;

  assign odd_cycle       = cycle_count[0];
  assign raw[EVT_CLOSE]  = odd_cycle & static_end;
  assign raw[EVT_FIRE]   = odd_cycle & nit_start;

  for (genvar e = 0; e < NEVT; e++) begin : g_once
    ecs_once #(.CYCLE_W(CYCLE_W)) u_once (
      .clk        (clk),
      .rst        (rst),
      .cycle_count(cycle_count),
      .trig       (raw[e]),
      .first      (first[e])
    );
  end

  assign evt.close = first[EVT_CLOSE];
  assign evt.fire  = first[EVT_FIRE];

endmodule

// File: rtl/ecs_path.sv
// One correction path: held value (written by host), committed value (frozen
// at window close), and the registered release outputs.
module ecs_path #(
  parameter int unsigned VAL_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  ecs_pkg::pair_evt_t evt,
  input  logic               wr,
  input  logic [VAL_W-1:0]   wdata,
  output logic               apply,
  output logic               valid,
  output logic [VAL_W-1:0]   value
);

  logic             hold_q;
  logic [VAL_W-1:0] hold_val_q;
  logic             commit_q;
  logic [VAL_W-1:0] commit_val_q;

  logic             hold_d;
  logic [VAL_W-1:0] hold_val_d;
  logic             commit_d;
  logic [VAL_W-1:0] commit_val_d;
  logic             fresh;

  // Incoming write merged with what is already held.
  always_comb begin
    hold_d     = hold_q | wr;
    hold_val_d = wr ? wdata : hold_val_q;
  end

  // Window close moves the held value into the commit stage.
  always_comb begin
    commit_d     = commit_q;
    commit_val_d = commit_val_q;
    if (evt.close && hold_d) begin
      commit_d     = 1'b1;
      commit_val_d = hold_val_d;
    end
  end

  assign fresh = evt.fire & commit_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q       <= 1'b0;
      hold_val_q   <= '0;
      commit_q     <= 1'b0;
      commit_val_q <= '0;
      apply        <= 1'b0;
      valid        <= 1'b0;
      value        <= '0;
    end else begin
      hold_val_q   <= hold_val_d;
      hold_q       <= evt.close ? 1'b0 : hold_d;
      commit_val_q <= commit_val_d;
      commit_q     <= evt.fire ? 1'b0 : commit_d;
      apply        <= evt.fire;
      valid        <= fresh;
      value        <= fresh ? commit_val_d : '0;
    end
  end

endmodule

// File: rtl/ext_corr_sched.sv
module ext_corr_sched #(
  parameter int unsigned CYCLE_W = 6,
  parameter int unsigned VAL_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CYCLE_W-1:0] cycle_count,
  input  logic               static_end,
  input  logic               nit_start,
  input  logic               ofs_wr,
  input  logic [VAL_W-1:0]   ofs_wdata,
  input  logic               rate_wr,
  input  logic [VAL_W-1:0]   rate_wdata,
  output logic               ofs_apply,
  output logic               ofs_valid,
  output logic [VAL_W-1:0]   ofs_value,
  output logic               rate_apply,
  output logic               rate_valid,
  output logic [VAL_W-1:0]   rate_value
);

  import ecs_pkg::*;

  pair_evt_t              evt;
  logic [NPATH-1:0]       wr_a;
  logic [VAL_W-1:0]       wdata_a [NPATH];
  logic [NPATH-1:0]       apply_a;
  logic [NPATH-1:0]       valid_a;
  logic [VAL_W-1:0]       value_a [NPATH];

  ecs_phase #(.CYCLE_W(CYCLE_W)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .cycle_count(cycle_count),
    .static_end (static_end),
    .nit_start  (nit_start),
    .evt        (evt)
  );

  assign wr_a[PATH_OFS]     = ofs_wr;
  assign wr_a[PATH_RATE]    = rate_wr;
  assign wdata_a[PATH_OFS]  = ofs_wdata;
  assign wdata_a[PATH_RATE] = rate_wdata;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    ecs_path #(.VAL_W(VAL_W)) u_path (
      .clk  (clk),
      .rst  (rst),
      .evt  (evt),
      .wr   (wr_a[p]),
      .wdata(wdata_a[p]),
      .apply(apply_a[p]),
      .valid(valid_a[p]),
      .value(value_a[p])
    );
  end

  assign ofs_apply  = apply_a[PATH_OFS];
  assign ofs_valid  = valid_a[PATH_OFS];
  assign ofs_value  = value_a[PATH_OFS];
  assign rate_apply = apply_a[PATH_RATE];
  assign rate_valid = valid_a[PATH_RATE];
  assign rate_value = value_a[PATH_RATE];

endmodule

// File: rtl/ecs_checker.sv
module ecs_checker #(
  parameter int unsigned CYCLE_W = 6,
  parameter int unsigned VAL_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [CYCLE_W-1:0] cycle_count,
  input logic               nit_start,
  input logic               ofs_wr,
  input logic               rate_wr,
  input logic               ofs_apply,
  input logic               ofs_valid,
  input logic [VAL_W-1:0]   ofs_value,
  input logic               rate_apply,
  input logic               rate_valid,
  input logic [VAL_W-1:0]   rate_value
);

  logic rst_q = 1'b0;
  logic ofs_seen, rate_seen;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      ofs_seen  <= 1'b0;
      rate_seen <= 1'b0;
    end else begin
      ofs_seen  <= ofs_seen | ofs_wr;
      rate_seen <= rate_seen | rate_wr;
    end
  end

  // R1: nothing is released on the clock after a reset clock
  always_ff @(posedge clk) begin
    if (rst_q === 1'b1) begin
      assert_reset_quiet_R1: assert (!ofs_apply && !ofs_valid && !rate_apply && !rate_valid)
        else $error("outputs active after reset");
    end
  end

  assert_ofs_odd_nit_R2: assert property (@(posedge clk) disable iff (rst)
    ofs_apply |-> $past(nit_start && cycle_count[0]));
  assert_rate_odd_nit_R8: assert property (@(posedge clk) disable iff (rst)
    rate_apply |-> $past(nit_start && cycle_count[0]));
  assert_ofs_single_R9: assert property (@(posedge clk) disable iff (rst)
    ofs_apply |=> !ofs_apply);
  assert_rate_single_R9: assert property (@(posedge clk) disable iff (rst)
    rate_apply |=> !rate_apply);
  assert_ofs_valid_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    ofs_valid |-> ofs_apply);
  assert_rate_valid_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    rate_valid |-> rate_apply);
  assert_ofs_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !ofs_valid |-> (ofs_value == '0));
  assert_rate_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !rate_valid |-> (rate_value == '0));
  assert_ofs_needs_write_R3: assert property (@(posedge clk) disable iff (rst)
    ofs_valid |-> ofs_seen);
  assert_rate_needs_write_R8: assert property (@(posedge clk) disable iff (rst)
    rate_valid |-> rate_seen);

endmodule

bind ext_corr_sched ecs_checker #(.CYCLE_W(CYCLE_W), .VAL_W(VAL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cycle_count(cycle_count),
  .nit_start  (nit_start),
  .ofs_wr     (ofs_wr),
  .rate_wr    (rate_wr),
  .ofs_apply  (ofs_apply),
  .ofs_valid  (ofs_valid),
  .ofs_value  (ofs_value),
  .rate_apply (rate_apply),
  .rate_valid (rate_valid),
  .rate_value (rate_value)
);

// File: tb/ext_corr_sched_test.sv
`timescale 1ns/1ps
module ext_corr_sched_test;

  localparam int CW = 6;
  localparam int VW = 2;
  localparam int SLOTS = 8;
  localparam int S_END = 4;
  localparam int S_NIT = 5;
  localparam int NREL = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cycle_count = '0;
  logic static_end = 1'b0, nit_start = 1'b0;
  logic ofs_wr = 1'b0, rate_wr = 1'b0;
  logic [VW-1:0] ofs_wdata = '0, rate_wdata = '0;
  logic ofs_apply, ofs_valid, rate_apply, rate_valid;
  logic [VW-1:0] ofs_value, rate_value;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // writes per path (0 offset, 1 rate), up to two each; cycle -1 = none
  int wc [2][2];
  int ws [2][2];
  int wv [2][2];
  int start_cyc;
  int nit_len;

  always #5 clk = ~clk;

  ext_corr_sched #(.CYCLE_W(CW), .VAL_W(VW)) uut (
    .clk(clk), .rst(rst), .cycle_count(cycle_count),
    .static_end(static_end), .nit_start(nit_start),
    .ofs_wr(ofs_wr), .ofs_wdata(ofs_wdata),
    .rate_wr(rate_wr), .rate_wdata(rate_wdata),
    .ofs_apply(ofs_apply), .ofs_valid(ofs_valid), .ofs_value(ofs_value),
    .rate_apply(rate_apply), .rate_valid(rate_valid), .rate_value(rate_value)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // relative cycle in which a write at (rel cycle c, slot s) is released
  function automatic int target_of(input int c, input int s);
    if (((start_cyc + c) % 2) == 0) return c + 1;
    if (s <= S_END) return c;
    return c + 2;
  endfunction

  task automatic check_outputs(input bit fire, input int rel);
    for (int p = 0; p < 2; p++) begin
      bit   e_valid = 0;
      int   e_val = 0;
      int   hits = 0;
      bit   late = 0;
      bit   earlier = 0;
      string tag;
      int   a_app = (p == 0) ? int'(ofs_apply) : int'(rate_apply);
      int   a_vld = (p == 0) ? int'(ofs_valid) : int'(rate_valid);
      int   a_val = (p == 0) ? int'(ofs_value) : int'(rate_value);
      for (int w = 0; w < 2; w++) begin
        if (wc[p][w] >= 0) begin
          int t = target_of(wc[p][w], ws[p][w]);
          if (fire && t == rel) begin
            e_valid = 1; e_val = wv[p][w]; hits++;
            late = (t != wc[p][w] + 1) && (t != wc[p][w]);
          end
          if (t < rel) earlier = 1;
        end
      end
      if (p == 1) tag = "R8";
      else if (hits > 1) tag = "R7";
      else if (e_valid) tag = late ? "R4" : "R3";
      else if (earlier) tag = "R6";
      else tag = "R1";
      chk(a_app == int'(fire), fire ? "R2" : "R9", "apply", a_app, int'(fire));
      chk(a_vld == int'(e_valid), tag, "valid", a_vld, int'(e_valid));
      chk(a_val == e_val, e_valid ? "R5" : "R6", "value", a_val, e_val);
    end
  endtask

  task automatic run_case();
    bit prev_fire;
    int prev_rel;
    @(negedge clk);
    rst = 1'b1; ofs_wr = 0; rate_wr = 0; static_end = 0; nit_start = 0;
    cycle_count = CW'(start_cyc);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(!ofs_apply && !ofs_valid && !rate_apply && !rate_valid &&
        ofs_value == 0 && rate_value == 0, "R1", "reset outputs",
        int'({ofs_apply, ofs_valid, rate_apply, rate_valid}), 0);
    prev_fire = 0; prev_rel = 0;
    for (int rel = 0; rel < NREL; rel++) begin
      for (int slot = 0; slot < SLOTS; slot++) begin
        if (rel != 0 || slot != 0) begin
          @(negedge clk);
          check_outputs(prev_fire, prev_rel);
        end
        cycle_count = CW'((start_cyc + rel) % 64);
        static_end  = (slot == S_END);
        nit_start   = (slot == S_NIT) || (nit_len == 2 && slot == S_NIT + 1);
        ofs_wr = 0; rate_wr = 0;
        for (int w = 0; w < 2; w++) begin
          if (wc[0][w] == rel && ws[0][w] == slot) begin
            ofs_wr = 1; ofs_wdata = VW'(wv[0][w]);
          end
          if (wc[1][w] == rel && ws[1][w] == slot) begin
            rate_wr = 1; rate_wdata = VW'(wv[1][w]);
          end
        end
        prev_fire = (slot == S_NIT) && (((start_cyc + rel) % 2) == 1);
        prev_rel  = rel;
      end
    end
    @(negedge clk);
    check_outputs(prev_fire, prev_rel);
    ofs_wr = 0; rate_wr = 0; static_end = 0; nit_start = 0;
  endtask

  task automatic clear_writes();
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < 2; w++) begin
        wc[p][w] = -1; ws[p][w] = 0; wv[p][w] = 0;
      end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: no writes at all, nothing released
    start_cyc = 0; nit_len = 1; clear_writes();
    run_case();

    // R3/R4/R5/R8/R9: single write per path swept over window positions
    for (int si = 0; si < 2; si++) begin
      for (int c = 0; c < 2; c++) begin
        for (int s = 0; s < SLOTS; s++) begin
          for (int v = 0; v < 4; v++) begin
            start_cyc = (si == 0) ? 0 : 62;
            nit_len = (s % 2 == 1) ? 2 : 1;
            clear_writes();
            wc[0][0] = c;     ws[0][0] = s;             wv[0][0] = v;
            wc[1][0] = 1 - c; ws[1][0] = SLOTS - 1 - s; wv[1][0] = 3 - v;
            run_case();
          end
        end
      end
    end

    // R7: replacement before the close, last write wins
    start_cyc = 0; nit_len = 1; clear_writes();
    wc[0][0] = 0; ws[0][0] = 1; wv[0][0] = int'(ecs_pkg::CORR_INC);
    wc[0][1] = 1; ws[0][1] = 3; wv[0][1] = int'(ecs_pkg::CORR_DEC);
    run_case();

    // R7: write after the close leaves committed value and waits a pair
    start_cyc = 62; nit_len = 2; clear_writes();
    wc[0][0] = 1; ws[0][0] = 2; wv[0][0] = int'(ecs_pkg::CORR_INC);
    wc[0][1] = 1; ws[0][1] = 5; wv[0][1] = int'(ecs_pkg::CORR_DEC);
    wc[1][0] = 2; ws[1][0] = 7; wv[1][0] = int'(ecs_pkg::CORR_RSVD);
    wc[1][1] = 3; ws[1][1] = 6; wv[1][1] = int'(ecs_pkg::CORR_INC);
    run_case();

    finish_run();
  end

endmodule